// File: doc/BRIEF.md
# Unequal-Latency Completion and Writeback Stage

This block is the back end of an in-order-issue core that feeds three execution pipes of different depths: a single-stage integer pipe, a two-stage load/store pipe (address generation, then cache access) and a floating-point pipe whose results arrive one cycle later than load/store results. An instruction is handed over with its pipe, its destination register and an opaque result word. The block moves the word down the chosen pipe and then drives the core's one register-file write port when the word comes out.

Results from pipes of unequal depth can finish out of program order. If an older instruction would finish after a younger one that targets the same register, its stale write is cancelled instead of issue being stalled. Each accepted instruction gets a 4-bit sequence tag that wraps. A table holds, for each register, the tag of the youngest instruction issued to it. At retirement, a result writes only when its tag still matches that entry. When two pipes finish in the same cycle, one result is kept in a single holding slot. Issue is throttled so that slot can never overflow.

Top module: `multi_lat_wb`

## Requirements
- R1: With no competing result, an instruction accepted in cycle c on pipe code 0 (integer), 1 (load/store) or 2 (floating point) reaches the write port in cycle c+1, c+2 or c+3 respectively.
- R2: At most one result retires per cycle. When a result writes, `wb_we` is high for that cycle and `wb_addr`/`wb_data` carry its destination and result word.
- R3: A retiring result writes only if its tag equals the tag of the most recently accepted instruction to the same destination. An older result that finishes after a younger one to the same register never writes.
- R4: A retirement whose write is cancelled by R3 raises `wb_squash` for that one cycle with `wb_we` low. The two are never high together.
- R5: Among results ready in the same cycle, the held result retires first, then the lowest pipe code. Exactly one leftover is held and retires in a later cycle.
- R6: `iss_ready` is low while the holding slot is occupied. It is also low when accepting the offered instruction (pipe code from `iss_pipe`) would leave more than one finished result waiting in any upcoming cycle.
- R7: Register 0 is never written. A result for register 0 retires with neither `wb_we` nor `wb_squash`.
- R8: An offer with `iss_valid` low, with `iss_pipe` = 3, or while `iss_ready` is low launches nothing. It produces no write or squash and does not change the youngest-writer entry of its destination.
- R9: While `rst_n` is low and after its release, in-flight and held results are discarded. `wb_we` and `wb_squash` are low and `iss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iss_valid | input | 1 | Instruction offered this cycle |
| iss_pipe | input | 2 | Pipe code: 0 integer, 1 load/store, 2 floating point, 3 none |
| iss_dest | input | AW | Destination register index |
| iss_data | input | DW | Opaque result word carried down the pipe |
| iss_ready | output | 1 | Offer is accepted at this clock edge when high |
| wb_we | output | 1 | Register-file write enable |
| wb_addr | output | AW | Register-file write address |
| wb_data | output | DW | Register-file write data |
| wb_squash | output | 1 | A retiring result had its stale write cancelled |

## Verification
Every cycle, the assertions check properties that hold in each cycle on their own. A squash never coincides with a write, and register 0 is never written. A held result always retires in the very next cycle. Issue stays closed while the slot is full, and the sequence tag does not move without an accepted instruction. Whether a particular write is the right one, which register holds the final value after a stale write, and the order in which colliding results reach the port depend on program order. The bench's reference model and its scenarios show these: same-register pairs across pipes, three-way collisions, register 0, refused or pipe-3 offers, and a reset with work in flight.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int NUM_PIPES = 3;
  localparam logic [1:0] PIPE_INT  = 2'd0;
  localparam logic [1:0] PIPE_LS   = 2'd1;
  localparam logic [1:0] PIPE_FP   = 2'd2;
  localparam logic [1:0] PIPE_NONE = 2'd3;
endpackage

// File: rtl/wb_pipe.sv
module wb_pipe #(
  parameter int LAT    = 1,
  parameter int MAXLAT = 3,
  parameter int AW     = 5,
  parameter int TW     = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     in_dest,
  input  logic [TW-1:0]     in_tag,
  input  logic [DW-1:0]     in_data,
  output logic              out_vld,
  output logic [AW-1:0]     out_dest,
  output logic [TW-1:0]     out_tag,
  output logic [DW-1:0]     out_data,
  output logic [MAXLAT:0]   due
);
  localparam int PW = AW + TW + DW;

  logic [LAT-1:0] vld_q, vld_d;
  logic [PW-1:0]  pay_q [LAT];
  logic [PW-1:0]  pay_d [LAT];

  always_comb begin
    vld_d[0] = load;
    pay_d[0] = {in_dest, in_tag, in_data};
    for (int s = 1; s < LAT; s++) begin
      vld_d[s] = vld_q[s-1];
      pay_d[s] = pay_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload has no reset; each stage loads only when its valid will be set
  always_ff @(posedge clk) begin
    for (int s = 0; s < LAT; s++) begin
      if (vld_d[s]) pay_q[s] <= pay_d[s];
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign {out_dest, out_tag, out_data} = pay_q[LAT-1];

  // due[d]: an entry finishes d cycles from now
  always_comb begin
    due = '0;
    for (int s = 0; s < LAT; s++) due[LAT-1-s] = vld_q[s];
  end
endmodule

// File: rtl/wb_tag_table.sv
module wb_tag_table #(
  parameter int NREG = 32,
  parameter int AW   = 5,
  parameter int TW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [AW-1:0] upd_reg,
  input  logic [TW-1:0] upd_tag,
  input  logic [AW-1:0] rd_reg,
  output logic [TW-1:0] rd_tag
);
  logic [TW-1:0] tab_q [NREG];
  logic [TW-1:0] tab_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      tab_d[r] = (upd && upd_reg == AW'(r)) ? upd_tag : tab_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) tab_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) tab_q[r] <= tab_d[r];
    end
  end

  assign rd_tag = tab_q[rd_reg];
endmodule

// File: rtl/wb_slot_check.sv
module wb_slot_check
  import wb_pkg::*;
#(
  parameter int MAXLAT = 3,
  parameter int LAT0   = 1,
  parameter int LAT1   = 2,
  parameter int LAT2   = 3
) (
  input  logic            hold_vld,
  input  logic [MAXLAT:0] due0,
  input  logic [MAXLAT:0] due1,
  input  logic [MAXLAT:0] due2,
  input  logic [1:0]      new_pipe,
  output logic            fits
);
  // Walk the upcoming cycles: the port drains one result per cycle,
  // whatever is left over must fit in the single holding slot.
  always_comb begin
    int backlog;
    int arrive;
    fits    = 1'b1;
    backlog = hold_vld ? 1 : 0;
    for (int d = 0; d <= MAXLAT; d++) begin
      arrive = (due0[d] ? 1 : 0) + (due1[d] ? 1 : 0) + (due2[d] ? 1 : 0);
      if (new_pipe == PIPE_INT && d == LAT0) arrive = arrive + 1;
      if (new_pipe == PIPE_LS  && d == LAT1) arrive = arrive + 1;
      if (new_pipe == PIPE_FP  && d == LAT2) arrive = arrive + 1;
      backlog = backlog + arrive;
      if (backlog > 0) backlog = backlog - 1;
      if (backlog > 1) fits = 1'b0;
    end
  end
endmodule

// File: rtl/wb_retire.sv
module wb_retire
  import wb_pkg::*;
#(
  parameter int AW = 5,
  parameter int TW = 4,
  parameter int DW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PIPES-1:0]          c_vld,
  input  logic [NUM_PIPES-1:0][AW-1:0]  c_dest,
  input  logic [NUM_PIPES-1:0][TW-1:0]  c_tag,
  input  logic [NUM_PIPES-1:0][DW-1:0]  c_data,
  output logic [AW-1:0]                 lk_reg,
  input  logic [TW-1:0]                 lk_tag,
  output logic                          wb_we,
  output logic [AW-1:0]                 wb_addr,
  output logic [DW-1:0]                 wb_data,
  output logic                          wb_squash,
  output logic                          hold_vld,
  output logic [AW-1:0]                 hold_dest
);
  logic          hold_q, hold_d;
  logic [AW-1:0] hdest_q, lo_dest;
  logic [TW-1:0] htag_q, lo_tag;
  logic [DW-1:0] hdata_q, lo_data;
  logic          sel_vld, lo_vld;
  logic [AW-1:0] sel_dest;
  logic [TW-1:0] sel_tag;
  logic [DW-1:0] sel_data;
  logic          live;

  // held result first, then pipes in order of increasing latency
  always_comb begin
    sel_vld  = hold_q;
    sel_dest = hdest_q;
    sel_tag  = htag_q;
    sel_data = hdata_q;
    lo_vld   = 1'b0;
    lo_dest  = c_dest[0];
    lo_tag   = c_tag[0];
    lo_data  = c_data[0];
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (c_vld[p]) begin
        if (!sel_vld) begin
          sel_vld  = 1'b1;
          sel_dest = c_dest[p];
          sel_tag  = c_tag[p];
          sel_data = c_data[p];
        end else begin
          lo_vld  = 1'b1;
          lo_dest = c_dest[p];
          lo_tag  = c_tag[p];
          lo_data = c_data[p];
        end
      end
    end
  end

  assign lk_reg    = sel_dest;
  assign live      = sel_vld && (sel_dest != '0);
  assign wb_we     = live && (sel_tag == lk_tag);
  assign wb_squash = live && (sel_tag != lk_tag);
  assign wb_addr   = sel_dest;
  assign wb_data   = sel_data;
  assign hold_d    = lo_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_ff @(posedge clk) begin
    if (lo_vld) begin
      hdest_q <= lo_dest;
      htag_q  <= lo_tag;
      hdata_q <= lo_data;
    end
  end

  assign hold_vld  = hold_q;
  assign hold_dest = hdest_q;
endmodule

// File: rtl/multi_lat_wb.sv
module multi_lat_wb
  import wb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int DW      = 32,
  parameter int TW      = 4,
  parameter int INT_LAT = 1,
  parameter int LS_LAT  = 2,
  parameter int FP_LAT  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [1:0]              iss_pipe,
  input  logic [$clog2(NREG)-1:0] iss_dest,
  input  logic [DW-1:0]           iss_data,
  output logic                    iss_ready,
  output logic                    wb_we,
  output logic [$clog2(NREG)-1:0] wb_addr,
  output logic [DW-1:0]           wb_data,
  output logic                    wb_squash
);
  localparam int AW     = $clog2(NREG);
  localparam int MAXLAT = (FP_LAT > LS_LAT) ? ((FP_LAT > INT_LAT) ? FP_LAT : INT_LAT)
                                            : ((LS_LAT > INT_LAT) ? LS_LAT : INT_LAT);
  localparam int PIPE_LAT [NUM_PIPES] = '{INT_LAT, LS_LAT, FP_LAT};

  logic                          accept;
  logic                          fits;
  logic                          hold_vld;
  logic [AW-1:0]                 hold_dest;
  logic [TW-1:0]                 tag_q, tag_d;
  logic [NUM_PIPES-1:0]          c_vld;
  logic [NUM_PIPES-1:0][AW-1:0]  c_dest;
  logic [NUM_PIPES-1:0][TW-1:0]  c_tag;
  logic [NUM_PIPES-1:0][DW-1:0]  c_data;
  logic [NUM_PIPES-1:0][MAXLAT:0] due;
  logic [AW-1:0]                 lk_reg;
  logic [TW-1:0]                 lk_tag;

  assign iss_ready = !hold_vld && fits;
  assign accept    = iss_valid && iss_ready && (iss_pipe != PIPE_NONE);
  assign tag_d     = accept ? tag_q + 1'b1 : tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  for (genvar gp = 0; gp < NUM_PIPES; gp++) begin : g_pipe
    wb_pipe #(
      .LAT(PIPE_LAT[gp]), .MAXLAT(MAXLAT), .AW(AW), .TW(TW), .DW(DW)
    ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && (iss_pipe == 2'(gp))),
      .in_dest  (iss_dest),
      .in_tag   (tag_q),
      .in_data  (iss_data),
      .out_vld  (c_vld[gp]),
      .out_dest (c_dest[gp]),
      .out_tag  (c_tag[gp]),
      .out_data (c_data[gp]),
      .due      (due[gp])
    );
  end

  wb_slot_check #(
    .MAXLAT(MAXLAT), .LAT0(INT_LAT), .LAT1(LS_LAT), .LAT2(FP_LAT)
  ) u_slot (
    .hold_vld (hold_vld),
    .due0     (due[0]),
    .due1     (due[1]),
    .due2     (due[2]),
    .new_pipe (iss_pipe),
    .fits     (fits)
  );

  wb_tag_table #(.NREG(NREG), .AW(AW), .TW(TW)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (accept),
    .upd_reg (iss_dest),
    .upd_tag (tag_q),
    .rd_reg  (lk_reg),
    .rd_tag  (lk_tag)
  );

  wb_retire #(.AW(AW), .TW(TW), .DW(DW)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .c_vld     (c_vld),
    .c_dest    (c_dest),
    .c_tag     (c_tag),
    .c_data    (c_data),
    .lk_reg    (lk_reg),
    .lk_tag    (lk_tag),
    .wb_we     (wb_we),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .wb_squash (wb_squash),
    .hold_vld  (hold_vld),
    .hold_dest (hold_dest)
  );
endmodule

// File: rtl/multi_lat_wb_chk.sv
module multi_lat_wb_chk #(
  parameter int AW = 5,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic [1:0]    iss_pipe,
  input logic          iss_ready,
  input logic          wb_we,
  input logic [AW-1:0] wb_addr,
  input logic          wb_squash,
  input logic          hold_vld,
  input logic [AW-1:0] hold_dest,
  input logic [TW-1:0] tag_q
);
  // R4: a cancelled write never coincides with a real one
  a_r4_squash_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_we && wb_squash));

  // R7: register 0 is never the target of a write
  a_r7_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_addr != '0));

  // R6: issue closed while the holding slot is occupied
  a_r6_closed_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> !iss_ready);

  // R5: a held result retires in the cycle it is held (it has top priority)
  a_r5_held_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && hold_dest != '0) |-> (wb_we || wb_squash));

  // R8: the sequence tag advances only on an accepted instruction
  a_r8_tag_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && iss_ready && iss_pipe != 2'd3) |=> $stable(tag_q));
endmodule

bind multi_lat_wb multi_lat_wb_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_pipe  (iss_pipe),
  .iss_ready (iss_ready),
  .wb_we     (wb_we),
  .wb_addr   (wb_addr),
  .wb_squash (wb_squash),
  .hold_vld  (hold_vld),
  .hold_dest (hold_dest),
  .tag_q     (tag_q)
);

// File: tb/multi_lat_wb_bench.sv
module multi_lat_wb_bench;
  localparam int NREG = 32;
  localparam int AW   = $clog2(NREG);
  localparam int DW   = 32;

  logic          clk;
  logic          rst_n;
  logic          iss_valid;
  logic [1:0]    iss_pipe;
  logic [AW-1:0] iss_dest;
  logic [DW-1:0] iss_data;
  logic          iss_ready;
  logic          wb_we;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          wb_squash;

  multi_lat_wb u_multi_lat_wb (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_pipe(iss_pipe),
    .iss_dest(iss_dest), .iss_data(iss_data), .iss_ready(iss_ready),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data), .wb_squash(wb_squash)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int due;
    int dest;
    int tag;
    int data;
    int pipe;
  } item_t;

  item_t pend[$];
  item_t hold_it;
  bit    hold_has;
  int    latest [NREG];
  int    tagc;
  int    cyc;
  int    n_chk;
  int    n_fail;
  bit    obs_we, obs_sq, obs_rdy;
  int    obs_addr, obs_data;
  bit    done;

  function automatic int lat_of(input int p);
    return (p == 0) ? 1 : (p == 1) ? 2 : 3;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    pend.delete();
    hold_has = 1'b0;
    for (int r = 0; r < NREG; r++) latest[r] = 0;
    tagc = 0;
  endtask

  // one cycle: drive at negedge, compare, advance model at posedge
  task automatic step(input bit v, input int p, input int d, input int dat);
    bit    sv, lv, ewe, esq, erdy, acc;
    item_t s, lo;
    int    b, a;
    iss_valid = v;
    iss_pipe  = 2'(p);
    iss_dest  = AW'(d);
    iss_data  = DW'(dat);
    #2;
    sv = hold_has;
    lv = 1'b0;
    if (hold_has) s = hold_it;
    for (int q = 0; q < 3; q++) begin
      foreach (pend[i]) begin
        if (pend[i].due == cyc && pend[i].pipe == q) begin
          if (!sv) begin s = pend[i]; sv = 1'b1; end
          else begin lo = pend[i]; lv = 1'b1; end
        end
      end
    end
    ewe = sv && s.dest != 0 && s.tag == latest[s.dest];
    esq = sv && s.dest != 0 && s.tag != latest[s.dest];
    b = hold_has ? 1 : 0;
    erdy = !hold_has;
    for (int k = 0; k <= 3; k++) begin
      a = 0;
      foreach (pend[i]) if (pend[i].due == cyc + k) a++;
      if (p != 3 && lat_of(p) == k) a++;
      b = b + a;
      if (b > 0) b--;
      if (b > 1) erdy = 1'b0;
    end
    chk("R2", "wb_we", longint'(wb_we), longint'(ewe));
    chk("R4", "wb_squash", longint'(wb_squash), longint'(esq));
    chk("R6", "iss_ready", longint'(iss_ready), longint'(erdy));
    if (ewe) begin
      chk("R3 R5", "wb_addr", longint'(wb_addr), longint'(s.dest));
      chk("R3 R5", "wb_data", longint'(wb_data), longint'(unsigned'(s.data)));
    end
    obs_we = wb_we; obs_sq = wb_squash; obs_rdy = iss_ready;
    obs_addr = int'(wb_addr); obs_data = int'(wb_data);
    acc = v && erdy && p != 3;
    @(posedge clk);
    for (int i = pend.size() - 1; i >= 0; i--) if (pend[i].due == cyc) pend.delete(i);
    hold_has = lv;
    if (lv) hold_it = lo;
    if (acc) begin
      item_t n;
      n.due = cyc + lat_of(p); n.dest = d; n.tag = tagc; n.data = dat; n.pipe = p;
      pend.push_back(n);
      latest[d] = tagc;
      tagc = (tagc + 1) % 16;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    for (int i = 0; i < 3; i++) begin @(posedge clk); @(negedge clk); end
    #2;
    chk("R9", "wb_we in reset", longint'(wb_we), 0);
    chk("R9", "wb_squash in reset", longint'(wb_squash), 0);
    chk("R9", "iss_ready in reset", longint'(iss_ready), 1);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int got, seen, bad, zw;
    done = 1'b0; n_chk = 0; n_fail = 0; cyc = 0;
    iss_valid = 1'b0; iss_pipe = '0; iss_dest = '0; iss_data = '0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: isolated latency per pipe
    for (int p = 0; p < 3; p++) begin
      step(1'b1, p, 7, 32'h100 + p);
      got = 0;
      for (int k = 1; k <= 6; k++) begin
        step(1'b0, 0, 0, 0);
        if (got == 0 && obs_we && obs_addr == 7) got = k;
      end
      chk("R1", $sformatf("latency pipe %0d", p), got, lat_of(p));
    end

    // R3/R4: older FP to r3 overtaken by younger INT to r3
    step(1'b1, 2, 3, 32'hD1);
    step(1'b1, 0, 3, 32'hD2);
    seen = 0; bad = 0;
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 0, 0, 0);
      seen += obs_sq ? 1 : 0;
      if (obs_we && obs_addr == 3 && obs_data == 32'hD1) bad++;
    end
    chk("R4", "squash count for stale FP", seen, 1);
    chk("R3", "stale write reached r3", bad, 0);

    // R5/R6: FP and LS collide, a third INT would overflow
    step(1'b1, 2, 4, 32'hE1);
    step(1'b1, 1, 5, 32'hE2);
    step(1'b1, 0, 6, 32'hE3);
    chk("R6", "ready for third colliding issue", longint'(obs_rdy), 0);
    step(1'b0, 0, 0, 0);
    chk("R5", "first of collision (LS) addr", obs_addr, 5);
    step(1'b0, 0, 0, 0);
    chk("R5", "held FP addr", obs_addr, 4);
    chk("R6", "ready while held", longint'(obs_rdy), 0);
    idle(3);

    // R7: register 0
    step(1'b1, 0, 0, 32'hAA);
    step(1'b0, 0, 0, 0);
    chk("R7", "r0 write", longint'(obs_we), 0);
    chk("R7", "r0 squash", longint'(obs_sq), 0);

    // R8: pipe 3 and valid-low offers to r6 leave the FP write alive
    step(1'b1, 2, 6, 32'hF1);
    step(1'b1, 3, 6, 32'hF2);
    step(1'b0, 0, 6, 32'hF3);
    seen = 0; bad = 0;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 0, 0, 0);
      if (obs_we && obs_addr == 6 && obs_data == 32'hF1) seen++;
      if (obs_we && obs_addr == 6 && obs_data != 32'hF1) bad++;
    end
    chk("R8", "FP write to r6 after ignored offers", seen, 1);
    chk("R8", "ignored offer produced a write", bad, 0);

    // R9: reset with work in flight
    step(1'b1, 2, 9, 32'h91);
    step(1'b1, 1, 10, 32'h92);
    do_reset();
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 0, 0, 0);
      if (obs_we || obs_sq) seen++;
    end
    chk("R9", "retirements after reset", seen, 0);

    // random traffic over a few registers, heavy in hazards
    zw = 0;
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 4), int'($urandom));
      if (obs_we && obs_addr == 0) zw++;
    end
    idle(6);
    chk("R7", "writes to r0 in random run", zw, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule